// File: doc/BRIEF.md
# Load-Reserved / Store-Conditional Reservation Monitor

This block sits in front of a small shared word memory and serves several processors through one request channel and one response channel per processor. Besides ordinary loads and stores it supports a load-reserved operation, which returns a word and records that the processor holds a reservation on its address, and a store-conditional operation, which performs its write only if that reservation is still intact. Processors use the pair to build lock-free read-modify-write sequences: read with load-reserved, compute, then attempt the store-conditional and retry on failure.

Every processor owns one reservation slot made of a valid flag and an address. A successful store-conditional cancels every other processor's reservation on the same address, and an ordinary store from one processor cancels other processors' reservations on the address it writes. Only one request is executed per clock, picked by a fixed priority, so each reservation check and the cancellations it causes happen as one indivisible step.

Requests use a valid/ready handshake; each accepted request produces one response, returned on the next cycle and held until the processor takes it. A processor whose response is still waiting is not granted again.

Top module: `lrsc_monitor`

## Requirements
- R1: After reset no response is pending and every reservation is clear, so a store-conditional issued first fails.
- R2: At most one request is accepted per cycle; among processors with a request and no pending response, the lowest index is accepted; a processor with a pending response is not accepted.
- R3: A request accepted at a clock edge shows its response valid right after that edge, and the response stays valid with stable data and status while its ready is low.
- R4: Operation code 2'b00 (plain load) returns the memory word at the address with status 1 and leaves all reservations unchanged.
- R5: Operation code 2'b10 (load-reserved) returns the memory word at the address with status 1 and sets the issuing processor's reservation to that address.
- R6: Operation code 2'b11 (store-conditional) with the issuer's reservation valid on the same address writes the data to memory and returns status 1 with data 0.
- R7: A store-conditional whose reservation is missing or on another address writes nothing and returns status 0 with data 0.
- R8: A successful store-conditional clears every other processor's reservation on that address; reservations on other addresses survive.
- R9: A store-conditional clears the issuer's own reservation whether it succeeds or fails.
- R10: Operation code 2'b01 (plain store) writes memory, returns status 1 with data 0, clears other processors' reservations on that address and keeps the issuer's own.
- R11: A new load-reserved replaces the issuer's earlier reservation, so only the latest address is held.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| req_valid | input | N_CPU | Request valid, one bit per processor |
| req_ready | output | N_CPU | Request accepted this cycle, one bit per processor |
| req_op | input | 2*N_CPU | Operation code per processor, 2 bits each |
| req_addr | input | N_CPU*ADDR_W | Word address per processor |
| req_wdata | input | N_CPU*DATA_W | Write data per processor |
| rsp_valid | output | N_CPU | Response valid per processor |
| rsp_ready | input | N_CPU | Response taken per processor |
| rsp_data | output | N_CPU*DATA_W | Read data per processor (0 for writes) |
| rsp_ok | output | N_CPU | Status: 0 only for a failed store-conditional |

## Verification
Random batches draw operations from a four-address window so that reservations, stores and store-conditionals from different processors collide often, which separates correct cancellation of other holders from over-eager or missing cancellation. Directed sequences take one reservation through each way it can die (own store-conditional, foreign store-conditional, foreign plain store, a newer load-reserved) and one way it must survive (the holder's own plain store), which tells apart per-address cancellation from global clearing. Simultaneous store-conditionals from two holders of the same address show that priority order decides the single winner, and a held response shows that a stalled processor is neither re-granted nor has its response overwritten.

// File: rtl/lrsc_pkg.sv
package lrsc_pkg;
  typedef enum logic [1:0] {
    OP_LOAD  = 2'b00,
    OP_STORE = 2'b01,
    OP_LR    = 2'b10,
    OP_SC    = 2'b11
  } mem_op_e;
endpackage

// File: rtl/lrsc_prio_arb.sv
module lrsc_prio_arb #(
  parameter int N_REQ = 4
) (
  input  logic [N_REQ-1:0] elig,
  output logic [N_REQ-1:0] gnt
);
  logic [N_REQ:0] blocked;

  assign blocked[0] = 1'b0;
  for (genvar i = 0; i < N_REQ; i++) begin : g_chain
    assign gnt[i]         = elig[i] & ~blocked[i];
    assign blocked[i + 1] = blocked[i] | elig[i];
  end
endmodule

// File: rtl/lrsc_resv_table.sv
module lrsc_resv_table
  import lrsc_pkg::*;
#(
  parameter int N_CPU  = 4,
  parameter int ADDR_W = 4
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [N_CPU-1:0]  act_cpu,
  input  mem_op_e           act_op,
  input  logic [ADDR_W-1:0] act_addr,
  output logic              sc_pass
);
  logic [N_CPU-1:0]  flag_q;
  logic [N_CPU-1:0]  flag_nxt;
  logic [N_CPU-1:0]  hit;
  logic [ADDR_W-1:0] addr_q [N_CPU];
  logic              foreign_kill;

  for (genvar i = 0; i < N_CPU; i++) begin : g_hit
    assign hit[i] = (addr_q[i] == act_addr);
  end

  assign sc_pass      = |(act_cpu & flag_q & hit);
  assign foreign_kill = (act_op == OP_STORE) || ((act_op == OP_SC) && sc_pass);

  for (genvar i = 0; i < N_CPU; i++) begin : g_slot
    logic addr_en;

    always_comb begin
      flag_nxt[i] = flag_q[i];
      if (act_cpu[i]) begin
        if (act_op == OP_LR)      flag_nxt[i] = 1'b1;
        else if (act_op == OP_SC) flag_nxt[i] = 1'b0;
      end else if ((|act_cpu) && foreign_kill && hit[i]) begin
        flag_nxt[i] = 1'b0;
      end
    end

    assign addr_en = act_cpu[i] && (act_op == OP_LR);

    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) flag_q[i] <= 1'b0;
      else        flag_q[i] <= flag_nxt[i];
    end

    always_ff @(posedge clk) begin
      if (addr_en) addr_q[i] <= act_addr;
    end
  end
endmodule

// File: rtl/lrsc_word_store.sv
module lrsc_word_store #(
  parameter int ADDR_W = 4,
  parameter int DATA_W = 32
) (
  input  logic              clk,
  input  logic              we,
  input  logic [ADDR_W-1:0] waddr,
  input  logic [DATA_W-1:0] wdata,
  input  logic [ADDR_W-1:0] raddr,
  output logic [DATA_W-1:0] rdata
);
  localparam int DEPTH = 1 << ADDR_W;

  logic [DATA_W-1:0] mem [DEPTH];

  always_ff @(posedge clk) begin
    if (we) mem[waddr] <= wdata;
  end

  assign rdata = mem[raddr];
endmodule

// File: rtl/lrsc_monitor.sv
module lrsc_monitor
  import lrsc_pkg::*;
#(
  parameter int N_CPU  = 4,
  parameter int ADDR_W = 4,
  parameter int DATA_W = 32
) (
  input  logic                     clk,
  input  logic                     rst_n,
  input  logic [N_CPU-1:0]         req_valid,
  output logic [N_CPU-1:0]         req_ready,
  input  logic [2*N_CPU-1:0]       req_op,
  input  logic [N_CPU*ADDR_W-1:0]  req_addr,
  input  logic [N_CPU*DATA_W-1:0]  req_wdata,
  output logic [N_CPU-1:0]         rsp_valid,
  input  logic [N_CPU-1:0]         rsp_ready,
  output logic [N_CPU*DATA_W-1:0]  rsp_data,
  output logic [N_CPU-1:0]         rsp_ok
);
  logic [1:0]        rst_sync;
  logic              run;
  logic [N_CPU-1:0]  elig;
  logic [N_CPU-1:0]  gnt;
  logic [1:0]        sel_op_raw;
  mem_op_e           sel_op;
  logic [ADDR_W-1:0] sel_addr;
  logic [DATA_W-1:0] sel_wdata;
  logic              sc_pass;
  logic              mem_we;
  logic [DATA_W-1:0] mem_rdata;
  logic [DATA_W-1:0] rsp_data_nxt;
  logic              rsp_ok_nxt;
  logic [N_CPU-1:0]  rsp_valid_q;
  logic [N_CPU-1:0]  rsp_valid_nxt;
  logic [DATA_W-1:0] rsp_data_q [N_CPU];
  logic [N_CPU-1:0]  rsp_ok_q;

  // reset asserts at once, releases on the clock
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rst_sync <= 2'b00;
    else        rst_sync <= {rst_sync[0], 1'b1};
  end
  assign run = rst_sync[1];

  assign elig      = req_valid & ~rsp_valid_q & {N_CPU{run}};
  assign req_ready = gnt;

  lrsc_prio_arb #(.N_REQ(N_CPU)) arb_i (
    .elig (elig),
    .gnt  (gnt)
  );

  always_comb begin
    sel_op_raw = '0;
    sel_addr   = '0;
    sel_wdata  = '0;
    for (int i = 0; i < N_CPU; i++) begin
      if (gnt[i]) begin
        sel_op_raw = sel_op_raw | req_op[2*i +: 2];
        sel_addr   = sel_addr   | req_addr[ADDR_W*i +: ADDR_W];
        sel_wdata  = sel_wdata  | req_wdata[DATA_W*i +: DATA_W];
      end
    end
  end
  assign sel_op = mem_op_e'(sel_op_raw);

  lrsc_resv_table #(.N_CPU(N_CPU), .ADDR_W(ADDR_W)) resv_i (
    .clk      (clk),
    .rst_n    (run),
    .act_cpu  (gnt),
    .act_op   (sel_op),
    .act_addr (sel_addr),
    .sc_pass  (sc_pass)
  );

  assign mem_we = (|gnt) && ((sel_op == OP_STORE) || ((sel_op == OP_SC) && sc_pass));

  lrsc_word_store #(.ADDR_W(ADDR_W), .DATA_W(DATA_W)) mem_i (
    .clk   (clk),
    .we    (mem_we),
    .waddr (sel_addr),
    .wdata (sel_wdata),
    .raddr (sel_addr),
    .rdata (mem_rdata)
  );

  always_comb begin
    rsp_data_nxt  = ((sel_op == OP_LOAD) || (sel_op == OP_LR)) ? mem_rdata : '0;
    rsp_ok_nxt    = !((sel_op == OP_SC) && !sc_pass);
    rsp_valid_nxt = gnt | (rsp_valid_q & ~rsp_ready);
  end

  always_ff @(posedge clk or negedge run) begin
    if (!run) rsp_valid_q <= '0;
    else      rsp_valid_q <= rsp_valid_nxt;
  end

  for (genvar i = 0; i < N_CPU; i++) begin : g_rsp
    always_ff @(posedge clk) begin
      if (gnt[i]) begin
        rsp_data_q[i] <= rsp_data_nxt;
        rsp_ok_q[i]   <= rsp_ok_nxt;
      end
    end
    assign rsp_data[DATA_W*i +: DATA_W] = rsp_data_q[i];
  end

  assign rsp_valid = rsp_valid_q;
  assign rsp_ok    = rsp_ok_q;
endmodule

// File: rtl/lrsc_monitor_chk.sv
module lrsc_monitor_chk #(
  parameter int N_CPU  = 4,
  parameter int DATA_W = 32
) (
  input logic                    clk,
  input logic                    rst_n,
  input logic [N_CPU-1:0]        req_valid,
  input logic [N_CPU-1:0]        req_ready,
  input logic [N_CPU-1:0]        rsp_valid,
  input logic [N_CPU-1:0]        rsp_ready,
  input logic [N_CPU*DATA_W-1:0] rsp_data,
  input logic [N_CPU-1:0]        rsp_ok
);
  // R2: one acceptance per cycle
  a_r2_one_grant: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0(req_valid & req_ready));

  for (genvar i = 0; i < N_CPU; i++) begin : g_cpu
    localparam logic [N_CPU-1:0] LOWER = N_CPU'((1 << i) - 1);

    // R2: no lower-index eligible requester is passed over
    a_r2_priority: assert property (@(posedge clk) disable iff (!rst_n)
      (req_valid[i] && req_ready[i]) |-> ((req_valid & ~rsp_valid & LOWER) == '0));

    // R2: pending response blocks a new acceptance
    a_r2_pending_blocks: assert property (@(posedge clk) disable iff (!rst_n)
      rsp_valid[i] |-> !req_ready[i]);

    // R3: response follows acceptance by one cycle
    a_r3_rsp_follows: assert property (@(posedge clk) disable iff (!rst_n)
      (req_valid[i] && req_ready[i]) |=> rsp_valid[i]);

    // R3: a stalled response holds still
    a_r3_rsp_hold: assert property (@(posedge clk) disable iff (!rst_n)
      (rsp_valid[i] && !rsp_ready[i]) |=>
        (rsp_valid[i] && $stable(rsp_data[DATA_W*i +: DATA_W]) && $stable(rsp_ok[i])));
  end
endmodule

bind lrsc_monitor lrsc_monitor_chk #(.N_CPU(N_CPU), .DATA_W(DATA_W)) chk_i (
  .clk       (clk),
  .rst_n     (rst_n),
  .req_valid (req_valid),
  .req_ready (req_ready),
  .rsp_valid (rsp_valid),
  .rsp_ready (rsp_ready),
  .rsp_data  (rsp_data),
  .rsp_ok    (rsp_ok)
);

// File: tb/lrsc_monitor_tb_top.sv
module lrsc_monitor_tb_top;
  localparam int N  = 4;
  localparam int AW = 4;
  localparam int DW = 32;
  localparam int DEPTH = 1 << AW;
  localparam logic [1:0] LD = 2'b00, ST = 2'b01, LR = 2'b10, SC = 2'b11;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic [N-1:0]    req_valid = '0;
  logic [N-1:0]    req_ready;
  logic [2*N-1:0]  req_op = '0;
  logic [N*AW-1:0] req_addr = '0;
  logic [N*DW-1:0] req_wdata = '0;
  logic [N-1:0]    rsp_valid;
  logic [N-1:0]    rsp_ready = '1;
  logic [N*DW-1:0] rsp_data;
  logic [N-1:0]    rsp_ok;

  always #5 clk = ~clk;

  lrsc_monitor #(.N_CPU(N), .ADDR_W(AW), .DATA_W(DW)) dut_i (
    .clk(clk), .rst_n(rst_n),
    .req_valid(req_valid), .req_ready(req_ready),
    .req_op(req_op), .req_addr(req_addr), .req_wdata(req_wdata),
    .rsp_valid(rsp_valid), .rsp_ready(rsp_ready),
    .rsp_data(rsp_data), .rsp_ok(rsp_ok)
  );

  int checks = 0;
  int fails  = 0;
  bit done   = 0;

  // bench model of the memory and reservations
  logic [DW-1:0] m_mem  [DEPTH];
  logic          m_flag [N];
  logic [AW-1:0] m_addr [N];

  // staged request per processor
  logic [1:0]    b_op   [N];
  logic [AW-1:0] b_addr [N];
  logic [DW-1:0] b_data [N];

  task automatic chk(input bit ok, input string req, input logic [DW-1:0] act, input logic [DW-1:0] exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic model_exec(input int c, input logic [1:0] op, input logic [AW-1:0] a,
                            input logic [DW-1:0] d, output logic [DW-1:0] ed, output logic eo);
    bit pass;
    pass = m_flag[c] && (m_addr[c] == a);
    ed = '0;
    eo = 1'b1;
    case (op)
      LD: ed = m_mem[a];
      LR: begin ed = m_mem[a]; m_flag[c] = 1'b1; m_addr[c] = a; end
      ST: begin
        m_mem[a] = d;
        for (int j = 0; j < N; j++) if (j != c && m_addr[j] == a) m_flag[j] = 1'b0;
      end
      default: begin
        eo = pass;
        if (pass) begin
          m_mem[a] = d;
          for (int j = 0; j < N; j++) if (j != c && m_addr[j] == a) m_flag[j] = 1'b0;
        end
        m_flag[c] = 1'b0;
      end
    endcase
  endtask

  function automatic string op_tag(input logic [1:0] op, input logic eo);
    case (op)
      LD: return "R4";
      ST: return "R10";
      LR: return "R5";
      default: return eo ? "R6" : "R7";
    endcase
  endfunction

  task automatic stage(input int c, input logic [1:0] op, input logic [AW-1:0] a, input logic [DW-1:0] d);
    b_op[c] = op; b_addr[c] = a; b_data[c] = d;
  endtask

  task automatic run_batch(input logic [N-1:0] mask, input string tag);
    logic [N-1:0]  pend, acc, got;
    logic [DW-1:0] ed [N];
    logic          eo [N];
    int cyc;
    for (int c = 0; c < N; c++) begin
      ed[c] = '0; eo[c] = 1'b0;
      if (mask[c]) model_exec(c, b_op[c], b_addr[c], b_data[c], ed[c], eo[c]);
    end
    @(negedge clk);
    for (int c = 0; c < N; c++) if (mask[c]) begin
      req_op[2*c +: 2]      = b_op[c];
      req_addr[AW*c +: AW]  = b_addr[c];
      req_wdata[DW*c +: DW] = b_data[c];
      req_valid[c]          = 1'b1;
    end
    pend = mask; got = '0; acc = '0; cyc = 0;
    while (got != mask && cyc < 60) begin
      #1;
      for (int c = 0; c < N; c++) begin
        if (acc[c]) chk(rsp_valid[c], "R3 response one cycle after accept", DW'(rsp_valid[c]), 1);
        if (rsp_valid[c] && !got[c]) begin
          got[c] = 1'b1;
          chk(rsp_data[DW*c +: DW] == ed[c], $sformatf("%s %s data cpu%0d", op_tag(b_op[c], eo[c]), tag, c),
              rsp_data[DW*c +: DW], ed[c]);
          chk(rsp_ok[c] == eo[c], $sformatf("%s %s status cpu%0d", op_tag(b_op[c], eo[c]), tag, c),
              DW'(rsp_ok[c]), DW'(eo[c]));
        end
      end
      acc = req_valid & req_ready;
      for (int c = 0; c < N; c++) if (acc[c]) begin
        chk((pend & N'((1 << c) - 1)) == '0, "R2 lowest index first", DW'(pend), DW'(pend & ~N'((1 << c) - 1)));
        pend[c] = 1'b0;
      end
      @(negedge clk);
      for (int c = 0; c < N; c++) if (acc[c]) req_valid[c] = 1'b0;
      cyc++;
    end
    chk(got == mask, "R3 all responses returned", DW'(got), DW'(mask));
    req_valid = '0;
  endtask

  task automatic one(input int c, input logic [1:0] op, input logic [AW-1:0] a,
                     input logic [DW-1:0] d, input string tag);
    stage(c, op, a, d);
    run_batch(N'(1 << c), tag);
  endtask

  initial begin
    #(10 * 150000);
    chk(1'b0, "watchdog expired", 0, 1);
    if (!done) begin
      done = 1;
      $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
      $finish;
    end
  end

  initial begin
    logic [DW-1:0] hold_d;
    logic [N-1:0]  mask;
    void'($urandom(32'd2024));
    for (int c = 0; c < N; c++) begin m_flag[c] = 1'b0; m_addr[c] = '0; end
    for (int a = 0; a < DEPTH; a++) m_mem[a] = '0;

    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    repeat (4) @(negedge clk);
    #1;
    chk(rsp_valid == '0, "R1 no response after reset", DW'(rsp_valid), 0);
    chk(req_ready == '0, "R1 idle ready low", DW'(req_ready), 0);

    one(2, SC, 4'd3, 32'hdead0001, "R1 first store-conditional fails");

    for (int a = 0; a < DEPTH; a++) one(0, ST, AW'(a), 32'h1000 + a, "R10 memory init");

    // R8: winner cancels other holders of the same address only
    one(1, LR, 4'd5, 0, "R5 hold a5");
    one(2, LR, 4'd5, 0, "R5 hold a5");
    one(3, LR, 4'd6, 0, "R5 hold a6");
    one(1, SC, 4'd5, 32'haaaa0005, "R6 winner");
    one(2, SC, 4'd5, 32'hbbbb0005, "R8 cancelled holder fails");
    one(3, SC, 4'd6, 32'hcccc0006, "R8 other address kept");
    one(1, LD, 4'd5, 0, "R4 reads winner data");
    one(2, LD, 4'd6, 0, "R4 reads a6");

    // R9: own flag cleared by success and by failure
    one(0, LR, 4'd7, 0, "R9 setup");
    one(0, SC, 4'd7, 32'h77, "R9 first passes");
    one(0, SC, 4'd7, 32'h78, "R9 second fails");
    one(0, LR, 4'd7, 0, "R9 setup");
    one(0, SC, 4'd8, 32'h88, "R9 wrong address fails");
    one(0, SC, 4'd7, 32'h79, "R9 flag gone after fail");

    // R4: plain load leaves reservation alone
    one(3, LR, 4'd10, 0, "R4 setup");
    one(1, LD, 4'd10, 0, "R4 foreign load");
    one(3, SC, 4'd10, 32'h1010, "R4 reservation survives load");

    // R11: newer reservation replaces older
    one(1, LR, 4'd2, 0, "R11 first");
    one(1, LR, 4'd3, 0, "R11 second");
    one(1, SC, 4'd2, 32'h22, "R11 old address fails");
    one(1, LR, 4'd3, 0, "R11 again");
    one(1, SC, 4'd3, 32'h33, "R11 latest address passes");

    // R10: foreign store kills, own store keeps
    one(2, LR, 4'd4, 0, "R10 setup");
    one(3, ST, 4'd4, 32'h4444, "R10 foreign store");
    one(2, SC, 4'd4, 32'h4545, "R10 killed by foreign store");
    one(2, LR, 4'd4, 0, "R10 setup");
    one(2, ST, 4'd4, 32'h4646, "R10 own store");
    one(2, SC, 4'd4, 32'h4747, "R10 kept after own store");

    // R2 + R8: simultaneous store-conditionals, priority decides winner
    one(0, LR, 4'd9, 0, "R2 setup");
    one(1, LR, 4'd9, 0, "R2 setup");
    stage(0, SC, 4'd9, 32'h9000);
    stage(1, SC, 4'd9, 32'h9001);
    run_batch(4'b0011, "R2 R8 race");
    for (int c = 0; c < N; c++) stage(c, LD, AW'(c), 0);
    run_batch(4'b1111, "R2 all at once");

    // R3 + R2: stalled response holds and blocks re-grant
    rsp_ready[1] = 1'b0;
    one(1, LR, 4'd12, 0, "R3 stall setup");
    hold_d = rsp_data[DW*1 +: DW];
    req_op[3:2] = LD; req_addr[AW +: AW] = 4'd13; req_valid[1] = 1'b1;
    for (int k = 0; k < 3; k++) begin
      @(negedge clk); #1;
      chk(rsp_valid[1], "R3 held valid", DW'(rsp_valid[1]), 1);
      chk(rsp_data[DW*1 +: DW] == hold_d, "R3 held data", rsp_data[DW*1 +: DW], hold_d);
      chk(!req_ready[1], "R2 pending blocks grant", DW'(req_ready[1]), 0);
    end
    req_valid[1] = 1'b0;
    rsp_ready[1] = 1'b1;
    @(negedge clk); #1;
    chk(!rsp_valid[1], "R3 released after ready", DW'(rsp_valid[1]), 0);
    one(1, SC, 4'd12, 32'hc0c0, "R6 reservation from stalled LR");

    // random mix on a narrow address window
    for (int t = 0; t < 400; t++) begin
      mask = N'($urandom % (1 << N));
      if (mask == '0) mask = 1;
      for (int c = 0; c < N; c++) stage(c, 2'($urandom % 4), AW'($urandom % 4), $urandom);
      run_batch(mask, "random");
    end

    if (!done) begin
      done = 1;
      $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
      $finish;
    end
  end
endmodule